// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one node's small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Every line has a tag, one data word and a coherence field that is Invalid, Shared or Modified. The processor side takes read and write requests. It answers hits at once and stalls misses by holding `cpu_ready_o` low. Misses and upgrades go out as bus transactions once the external arbiter grants the bus. A transaction finishes in its grant cycle, and its fill data arrives on `bus_rdata_i` in that same cycle.

The snoop port carries only the transactions granted to other nodes. Each snooped transaction is checked against the local line at its index. The controller can then supply dirty data, downgrade the line or invalidate it. The state of a line is therefore moved both by local requests and by bus traffic from other nodes. Writing to a clean shared line counts as a miss that broadcasts an invalidate.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: A read whose address tag matches a line in Shared or Modified state raises `cpu_ready_o` in the same cycle. It returns the line data on `cpu_rdata_o` and raises no bus request.
- R2: A read that finds its line Invalid, or holding another tag in Shared state, issues command 0 (shared read) for the requested address. The line is filled from `bus_rdata_i` and becomes Shared, so the read then hits.
- R3: A read or write that must evict a Modified line holding another tag first issues command 3 (writeback) with the victim's address and data. Only after that does it issue its own request.
- R4: A write that hits a Shared line issues command 2 (upgrade) and then holds the line Modified with the written data. A peer holding a Shared copy drops it to Invalid.
- R5: A write to a line that is Invalid or holds another tag issues command 1 (exclusive read). The line then holds the written data in Modified state, and every peer copy becomes Invalid.
- R6: A snooped command 0 that hits a local Modified line raises `snp_flush_o` with the line data on `snp_data_o` in that cycle. The line then becomes Shared.
- R7: A snooped command 1 or 2 that hits a local Shared line makes it Invalid. A snooped command 1 that hits a local Modified line first supplies the data, as in R6, and then makes the line Invalid.
- R8: A bus transaction takes effect only in a cycle with `bus_gnt_i`, and each transaction comes from a single granted node. A snooped transaction wins over the processor: `cpu_ready_o` stays low in any cycle with `snp_valid_i`.
- R9: After reset every line is Invalid: no bus request is raised without a processor request, and the first access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address: low IDX_W bits index, rest tag |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data, valid with ready |
| bus_req_o | output | 1 | Request for the bus |
| bus_gnt_i | input | 1 | Grant; the transaction completes this cycle |
| bus_cmd_o | output | 2 | 0 read, 1 exclusive read, 2 upgrade, 3 writeback |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Writeback data |
| bus_rdata_i | input | DATA_W | Fill data in the grant cycle |
| snp_valid_i | input | 1 | A transaction granted to another node is on the bus |
| snp_cmd_i | input | 2 | Command of the snooped transaction |
| snp_addr_i | input | ADDR_W | Address of the snooped transaction |
| snp_flush_o | output | 1 | This node supplies dirty data for the snoop |
| snp_data_o | output | DATA_W | Supplied data |

## Verification
A wrong coherence state shows up at the ports within one transaction. A line left Shared when it should be Invalid makes a later read return stale data without any bus traffic. A line wrongly left Modified makes a peer's miss draw a spurious flush. A lost Modified state turns a write hit into an extra upgrade or exclusive read on the bus. The bench runs two controllers over a modelled bus and memory, so every state error surfaces either in the command trace of the next access to that index or in the value that the next read returns.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    CMD_RD    = 2'd0,
    CMD_RDX   = 2'd1,
    CMD_UPGR  = 2'd2,
    CMD_FLUSH = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  line_state_e       wr_state_i,
  input  logic              wr_data_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output line_state_e       cpu_state_o,
  output logic [DATA_W-1:0] cpu_data_o,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output logic [TAG_W-1:0]  snp_tag_o,
  output line_state_e       snp_state_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_a  [LINES];
  line_state_e       st_a   [LINES];
  logic [DATA_W-1:0] data_a [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [TAG_W-1:0]  tag_q;
    line_state_e       st_q;
    logic [DATA_W-1:0] data_q;
    logic              sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q  <= '0;
        st_q   <= ST_I;
        data_q <= '0;
      end else if (sel) begin
        tag_q <= wr_tag_i;
        st_q  <= wr_state_i;
        if (wr_data_en_i) data_q <= wr_data_i;
      end
    end

    assign tag_a[i]  = tag_q;
    assign st_a[i]   = st_q;
    assign data_a[i] = data_q;
  end

  assign cpu_tag_o   = tag_a[cpu_idx_i];
  assign cpu_state_o = st_a[cpu_idx_i];
  assign cpu_data_o  = data_a[cpu_idx_i];
  assign snp_tag_o   = tag_a[snp_idx_i];
  assign snp_state_o = st_a[snp_idx_i];
  assign snp_data_o  = data_a[snp_idx_i];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             valid_i,
  input  bus_cmd_e         cmd_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  line_state_e      line_state_i,
  output logic             upd_o,
  output line_state_e      next_state_o,
  output logic             supply_o
);
  logic hit;
  assign hit = valid_i && (line_state_i != ST_I) && (line_tag_i == tag_i);

  always_comb begin
    upd_o        = 1'b0;
    next_state_o = line_state_i;
    supply_o     = 1'b0;
    if (hit) begin
      unique case (cmd_i)
        CMD_RD: begin
          if (line_state_i == ST_M) begin
            upd_o        = 1'b1;
            next_state_o = ST_S;
            supply_o     = 1'b1;
          end
        end
        CMD_RDX: begin
          upd_o        = 1'b1;
          next_state_o = ST_I;
          supply_o     = (line_state_i == ST_M);
        end
        CMD_UPGR: begin
          upd_o        = 1'b1;
          next_state_o = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_miss_unit.sv
module msi_miss_unit
  import msi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              we_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  line_state_e       line_state_i,
  output logic              match_o,
  output logic              hit_o,
  output bus_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic victim;

  assign match_o = (line_state_i != ST_I) && (line_tag_i == req_tag_i);
  assign hit_o   = match_o && (!we_i || line_state_i == ST_M);
  assign victim  = (line_state_i == ST_M) && !match_o;

  always_comb begin
    if (victim)     cmd_o = CMD_FLUSH;
    else if (!we_i) cmd_o = CMD_RD;
    else if (match_o) cmd_o = CMD_UPGR;  // clean shared copy: ownership only
    else            cmd_o = CMD_RDX;
  end

  assign addr_o = victim ? {line_tag_i, idx_i} : {req_tag_i, idx_i};
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  logic [TAG_W-1:0]  c_tag, s_tag;
  line_state_e       c_state, s_state;
  logic [DATA_W-1:0] c_data, s_data;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  logic              wr_en, wr_data_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  line_state_e       wr_state;
  logic [DATA_W-1:0] wr_data;

  msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag), .wr_state_i(wr_state),
    .wr_data_en_i(wr_data_en), .wr_data_i(wr_data),
    .cpu_idx_i(cpu_idx), .cpu_tag_o(c_tag), .cpu_state_o(c_state), .cpu_data_o(c_data),
    .snp_idx_i(snp_idx), .snp_tag_o(s_tag), .snp_state_o(s_state), .snp_data_o(s_data)
  );

  logic        c_match, c_hit;
  bus_cmd_e    miss_cmd;

  msi_miss_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_miss (
    .we_i(cpu_we_i), .req_tag_i(cpu_tag), .idx_i(cpu_idx),
    .line_tag_i(c_tag), .line_state_i(c_state),
    .match_o(c_match), .hit_o(c_hit), .cmd_o(miss_cmd), .addr_o(bus_addr_o)
  );

  logic        snp_upd;
  line_state_e snp_next;

  msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .valid_i(snp_valid_i), .cmd_i(bus_cmd_e'(snp_cmd_i)), .tag_i(snp_tag),
    .line_tag_i(s_tag), .line_state_i(s_state),
    .upd_o(snp_upd), .next_state_o(snp_next), .supply_o(snp_flush_o)
  );

  logic granted;

  assign bus_req_o   = cpu_req_i && !c_hit;  // no snoop term: avoids a grant loop between nodes
  assign granted     = bus_gnt_i && bus_req_o;
  assign bus_cmd_o   = miss_cmd;
  assign bus_wdata_o = c_data;
  assign cpu_ready_o = cpu_req_i && c_hit && !snp_valid_i;
  assign cpu_rdata_o = c_data;
  assign snp_data_o  = s_data;

  // one write port: snoop, then own grant, then local write hit
  always_comb begin
    wr_en      = 1'b0;
    wr_idx     = cpu_idx;
    wr_tag     = c_tag;
    wr_state   = c_state;
    wr_data_en = 1'b0;
    wr_data    = cpu_wdata_i;
    if (snp_upd) begin
      wr_en    = 1'b1;
      wr_idx   = snp_idx;
      wr_tag   = s_tag;
      wr_state = snp_next;
    end else if (granted) begin
      wr_en = 1'b1;
      unique case (miss_cmd)
        CMD_FLUSH: wr_state = ST_I;
        CMD_RD: begin
          wr_tag     = cpu_tag;
          wr_state   = ST_S;
          wr_data_en = 1'b1;
          wr_data    = bus_rdata_i;
        end
        CMD_RDX, CMD_UPGR: begin
          wr_tag     = cpu_tag;
          wr_state   = ST_M;
          wr_data_en = 1'b1;
        end
        default: ;
      endcase
    end else if (cpu_ready_o && cpu_we_i) begin
      wr_en      = 1'b1;
      wr_state   = ST_M;
      wr_data_en = 1'b1;
    end
  end

  AST_GNT_HAS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_gnt_i |-> bus_req_o);  // R8
  AST_SNP_NOT_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !bus_gnt_i);  // R8
  AST_RD_FILL_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted && bus_cmd_o == CMD_RD) |=> (!$stable(cpu_addr_i) || c_state == ST_S));  // R2
  AST_FLUSH_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted && bus_cmd_o == CMD_FLUSH) |=> (!$stable(cpu_addr_i) || c_state == ST_I));  // R3
  AST_OWN_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (granted && (bus_cmd_o == CMD_RDX || bus_cmd_o == CMD_UPGR)) |=>
      (!$stable(cpu_addr_i) || (c_state == ST_M && cpu_rdata_o == $past(cpu_wdata_i))));  // R5
  AST_SNP_RD_SHARES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == CMD_RD && snp_flush_o) |=>
      (!$stable(snp_addr_i) || s_state == ST_S));  // R6
  AST_SNP_INVALIDATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && (snp_cmd_i == CMD_RDX || snp_cmd_i == CMD_UPGR) &&
     s_state != ST_I && s_tag == snp_tag) |=>
      (!$stable(snp_addr_i) || s_state == ST_I));  // R7
  AST_SNP_BLOCKS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !cpu_ready_o);  // R8
endmodule

// File: tb/msi_snoop_ctrl_tb.sv
module msi_snoop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 2;
  localparam int MEM_N  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
  logic [DATA_W-1:0] a_wd = '0, b_wd = '0;
  logic              a_rdy, b_rdy, a_breq, b_breq, a_flush, b_flush;
  logic [DATA_W-1:0] a_rd, b_rd, a_bwd, b_bwd, a_sd, b_sd, a_fill, b_fill;
  logic [1:0]        a_cmd, b_cmd;
  logic [ADDR_W-1:0] a_baddr, b_baddr;
  logic              gnt_a, gnt_b, pri;
  logic [DATA_W-1:0] mem [MEM_N];

  assign gnt_a  = a_breq && (!b_breq || !pri);
  assign gnt_b  = b_breq && !gnt_a;
  assign a_fill = b_flush ? b_sd : mem[a_baddr];
  assign b_fill = a_flush ? a_sd : mem[b_baddr];

  msi_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(a_req), .cpu_we_i(a_we), .cpu_addr_i(a_addr), .cpu_wdata_i(a_wd),
    .cpu_ready_o(a_rdy), .cpu_rdata_o(a_rd),
    .bus_req_o(a_breq), .bus_gnt_i(gnt_a), .bus_cmd_o(a_cmd), .bus_addr_o(a_baddr),
    .bus_wdata_o(a_bwd), .bus_rdata_i(a_fill),
    .snp_valid_i(gnt_b), .snp_cmd_i(b_cmd), .snp_addr_i(b_baddr),
    .snp_flush_o(a_flush), .snp_data_o(a_sd)
  );

  msi_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_peer (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(b_req), .cpu_we_i(b_we), .cpu_addr_i(b_addr), .cpu_wdata_i(b_wd),
    .cpu_ready_o(b_rdy), .cpu_rdata_o(b_rd),
    .bus_req_o(b_breq), .bus_gnt_i(gnt_b), .bus_cmd_o(b_cmd), .bus_addr_o(b_baddr),
    .bus_wdata_o(b_bwd), .bus_rdata_i(b_fill),
    .snp_valid_i(gnt_a), .snp_cmd_i(a_cmd), .snp_addr_i(a_baddr),
    .snp_flush_o(b_flush), .snp_data_o(b_sd)
  );

  function automatic int init_val(int a);
    return (a * 37 + 11) & 16'hFFFF;
  endfunction

  // bus memory and arbitration
  always @(posedge clk) begin
    if (!rst_n) begin
      pri <= 1'b0;
      for (int i = 0; i < MEM_N; i++) mem[i] <= DATA_W'(init_val(i));
    end else begin
      if (gnt_a || gnt_b) pri <= ~pri;
      if (gnt_a && a_cmd == 2'd3) mem[a_baddr] <= a_bwd;
      if (gnt_a && b_flush)       mem[a_baddr] <= b_sd;
      if (gnt_b && b_cmd == 2'd3) mem[b_baddr] <= b_bwd;
      if (gnt_b && a_flush)       mem[b_baddr] <= a_sd;
    end
  end

  int checks = 0, fails = 0;
  int golden [MEM_N];
  int mst [2][4];
  int mtag [2][4];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int push(int t, int c);
    return (t << 3) | (4 | c);
  endfunction

  // expected bus trace from the requirements; 0 rd, 1 rdx, 2 upgr, 3 writeback
  task automatic model_op(int n, bit we, int addr, output int t, output int pf);
    int idx = addr & 3;
    int tag = addr >> 2;
    int o = 1 - n;
    bit match = mst[n][idx] != 0 && mtag[n][idx] == tag;
    bit pm = mst[o][idx] != 0 && mtag[o][idx] == tag;
    t = 0; pf = 0;
    if (!we) begin
      if (!match) begin
        if (mst[n][idx] == 2) t = push(t, 3);
        t = push(t, 0);
        if (pm && mst[o][idx] == 2) begin pf = 1; mst[o][idx] = 1; end
        mst[n][idx] = 1; mtag[n][idx] = tag;
      end
    end else if (match && mst[n][idx] == 1) begin
      t = push(t, 2);
      if (pm) mst[o][idx] = 0;
      mst[n][idx] = 2;
    end else if (!match) begin
      if (mst[n][idx] == 2) t = push(t, 3);
      t = push(t, 1);
      if (pm) begin
        if (mst[o][idx] == 2) pf = 1;
        mst[o][idx] = 0;
      end
      mst[n][idx] = 2; mtag[n][idx] = tag;
    end
  endtask

  task automatic run_op(int n, bit we, int addr, int wd,
                        output int trace, output int rdata, output int pflush);
    int guard = 0;
    @(negedge clk);
    if (n == 0) begin a_req = 1; a_we = we; a_addr = ADDR_W'(addr); a_wd = DATA_W'(wd); end
    else        begin b_req = 1; b_we = we; b_addr = ADDR_W'(addr); b_wd = DATA_W'(wd); end
    #1;
    trace = 0; rdata = 0; pflush = 0;
    forever begin
      if (n == 0 && gnt_a) begin trace = push(trace, int'(a_cmd)); if (b_flush) pflush = 1; end
      if (n == 1 && gnt_b) begin trace = push(trace, int'(b_cmd)); if (a_flush) pflush = 1; end
      if ((n == 0) ? a_rdy : b_rdy) begin
        rdata = (n == 0) ? int'(a_rd) : int'(b_rd);
        break;
      end
      guard++;
      if (guard > 40) begin
        check("R8 op timeout", 1, 0);
        break;
      end
      @(negedge clk); #1;
    end
    @(negedge clk);
    a_req = 0; b_req = 0;
  endtask

  task automatic do_op(string req, int n, bit we, int addr, int wd);
    int et, epf, t, rd, pf;
    model_op(n, we, addr, et, epf);
    run_op(n, we, addr, wd, t, rd, pf);
    check({req, " bus trace"}, t, et);
    check({req, " peer flush"}, pf, epf);
    if (we) golden[addr] = wd & 16'hFFFF;
    else    check({req, " read data"}, rd, golden[addr]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    int t, rd, pf;
    seed_init = $urandom(32'd1357);
    for (int i = 0; i < MEM_N; i++) golden[i] = init_val(i);
    for (int n = 0; n < 2; n++)
      for (int i = 0; i < 4; i++) begin mst[n][i] = 0; mtag[n][i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R9 reset ready low", int'(a_rdy), 0);
    check("R9 reset no bus req", int'(a_breq | b_breq), 0);

    do_op("R9 R2 first read misses", 0, 0, 8'h10, 0);
    do_op("R1 read hit shared", 0, 0, 8'h10, 0);
    do_op("R2 peer read miss", 1, 0, 8'h10, 0);

    // R8: snoop in the same cycle as a local hit
    @(negedge clk);
    a_req = 1; a_we = 0; a_addr = 8'h10;
    b_req = 1; b_we = 0; b_addr = 8'h33;
    #1;
    check("R8 grant to peer", int'(gnt_b), 1);
    check("R8 snoop blocks local hit", int'(a_rdy), 0);
    @(negedge clk); #1;
    check("R8 hit after snoop", int'(a_rdy), 1);
    check("R8 hit data", int'(a_rd), golden[8'h10]);
    check("R2 peer filled", int'(b_rdy), 1);
    check("R2 peer fill data", int'(b_rd), golden[8'h33]);
    @(negedge clk);
    a_req = 0; b_req = 0;
    model_op(1, 0, 8'h33, t, pf);

    do_op("R4 upgrade", 0, 1, 8'h10, 16'hA5A5);
    do_op("R7 R6 invalidated peer rereads", 1, 0, 8'h10, 0);
    do_op("R4 peer upgrade", 1, 1, 8'h10, 16'h5A5A);
    do_op("R6 supply on snooped read", 0, 0, 8'h10, 0);
    do_op("R5 write miss over shared", 0, 1, 8'h14, 16'h1234);
    do_op("R3 R5 writeback then rdx", 0, 1, 8'h18, 16'h4321);
    do_op("R3 writeback then read", 0, 0, 8'h10, 0);
    do_op("R5 write miss", 0, 1, 8'h21, 16'h0F0F);
    do_op("R7 rdx takes modified", 1, 1, 8'h21, 16'hF0F0);
    do_op("R6 read from peer modified", 0, 0, 8'h21, 0);

    for (int k = 0; k < 400; k++) begin
      int n = int'($urandom_range(1, 0));
      bit we = 1'($urandom_range(1, 0));
      int addr = int'({$urandom_range(3, 0), 2'b00}) | int'($urandom_range(3, 0));
      int wd = int'($urandom_range(16'hFFFF, 0));
      do_op("R1 R2 R3 R4 R5 R6 R7 random", n, we, addr, wd);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule